// File: doc/BRIEF.md
# Shift and Rotate Unit with Status Flags

This block is the shift and rotate datapath of an execution unit for a 16-bit processor. It takes one operand and produces the shifted or rotated value in a single combinational pass. It handles seven operations: rotate left and right, rotate left and right through the carry flag, shift left, logical shift right and arithmetic shift right. Each operation works on either the low byte or the full word of the operand.

The count arrives as an 8-bit value from the decoder. The decoder supplies 1 for the implicit-count forms and otherwise an immediate or the count register. A model select chooses how the count is masked: the original model uses all eight bits, and later models keep only the low five. The unit returns the result together with new carry, overflow, sign, zero and parity values. It also returns a per-flag write-enable vector, so that the surrounding status register can keep every flag the operation does not touch.

Top module: `shrot_unit`

## Requirements
- R1: With `late_model_i`=1 the effective count is `count_i[4:0]`. With `late_model_i`=0 it is all eight bits of `count_i`.
- R2: An effective count of zero returns the operand (low byte when `wide_i`=0) unchanged and drives `flag_we_o`=0. In that case `cf_o` equals `carry_i` and the other flag outputs are 0.
- R3: Rotate through carry treats {carry, operand} as a (W+1)-bit value and rotates it by the effective count modulo W+1, where W is 8 or 16. Left is op 2 and right is op 3. `cf_o` is the last bit rotated out. For op 2, OF is the result MSB XOR the new CF. For op 3, OF is the original operand MSB XOR `carry_i`.
- R4: Every rotate (ops 0 to 3) with a nonzero effective count drives `flag_we_o`=5'b00011, which writes only CF and OF. The sign, zero and parity outputs are then 0.
- R5: A plain rotate uses the effective count modulo W. Left is op 0 and right is op 1. After a left rotate CF is the result LSB, and after a right rotate CF is the result MSB.
- R6: For op 0, OF is the result MSB XOR the result LSB. For op 1, OF is the XOR of the two highest result bits.
- R7: Shift left (op 4, and op 6 as an alias) sets CF to the last bit shifted out and OF to the result MSB XOR CF. A count equal to W gives zero with CF equal to the original LSB. A count above W gives zero with CF=0.
- R8: Arithmetic shift right (op 7) fills with the sign bit and always drives OF=0. A count of W or more gives all sign bits, with CF equal to the sign.
- R9: Logical shift right (op 5) sets OF to the original MSB. A count equal to W gives zero with CF equal to the original MSB. A count above W gives zero with CF=0.
- R10: A shift with a nonzero effective count drives `flag_we_o`=5'b11111. The bit order is {PF,ZF,SF,OF,CF}, with CF in bit 0. SF is the result MSB, ZF is set for a zero result, and PF is 1 when the low 8 result bits hold an even number of ones.
- R11: With `wide_i`=0 only `opnd_i[7:0]` is used, `result_o[15:8]` is 0, and bit 7 is the MSB for every flag rule above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 16 | Operand value |
| carry_i | input | 1 | Current carry flag |
| count_i | input | 8 | Raw shift or rotate count |
| op_i | input | 3 | Operation code (see R3 to R9) |
| wide_i | input | 1 | 1 selects a 16-bit operand, 0 selects 8-bit |
| late_model_i | input | 1 | 1 masks the count to five bits |
| result_o | output | 16 | Shifted or rotated value, zero-extended in byte mode |
| cf_o | output | 1 | New carry flag |
| of_o | output | 1 | New overflow flag |
| sf_o | output | 1 | New sign flag |
| zf_o | output | 1 | New zero flag |
| pf_o | output | 1 | New parity flag |
| flag_we_o | output | 5 | Flag write enables {PF,ZF,SF,OF,CF} |

## Verification
The bench builds the unit with its default parameters: a 16-bit word lane, an 8-bit byte lane, an 8-bit count and five-bit masking for late models. With an unmasked 8-bit count, values far above both lane widths can be reached. This exposes the modulo-17 and modulo-9 wraps of rotate through carry, counts that are a multiple of the width for plain rotates, and counts equal to and greater than the width for every shift. Toggling the model select makes the same raw count collapse to zero, or to a small value, on late models.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

   typedef enum logic [2:0] {
      OP_ROL  = 3'd0,
      OP_ROR  = 3'd1,
      OP_RCL  = 3'd2,
      OP_RCR  = 3'd3,
      OP_SHL  = 3'd4,
      OP_SHR  = 3'd5,
      OP_SHL2 = 3'd6,
      OP_SAR  = 3'd7
   } shrot_op_e;

   localparam int FLAG_CF = 0;
   localparam int FLAG_OF = 1;
   localparam int FLAG_SF = 2;
   localparam int FLAG_ZF = 3;
   localparam int FLAG_PF = 4;
   localparam int NFLAGS  = 5;

   localparam logic [NFLAGS-1:0] WE_ROTATE = NFLAGS'((1 << FLAG_CF) | (1 << FLAG_OF));
   localparam logic [NFLAGS-1:0] WE_SHIFT  = '1;

   function automatic logic op_is_shift(input logic [2:0] op);
      return op[2];
   endfunction

endpackage

// File: rtl/shrot_count.sv
module shrot_count #(
   parameter int CNT_W         = 8,
   parameter int LATE_CNT_BITS = 5
) (
   input  logic [CNT_W-1:0] count_i,
   input  logic             late_i,
   output logic [CNT_W-1:0] eff_o,
   output logic             zero_o
);

   localparam int PAD_W = CNT_W - LATE_CNT_BITS;

   if (LATE_CNT_BITS < 1 || LATE_CNT_BITS > CNT_W) begin : g_bad_mask
      $error("shrot_count: LATE_CNT_BITS out of range");
   end

   logic [CNT_W-1:0] masked;

   if (PAD_W > 0) begin : g_pad
      assign masked = {{PAD_W{1'b0}}, count_i[LATE_CNT_BITS-1:0]};
   end else begin : g_nopad
      assign masked = count_i;
   end

   assign eff_o  = late_i ? masked : count_i;
   assign zero_o = (eff_o == '0);

endmodule

// File: rtl/shrot_lane.sv
module shrot_lane
   import shrot_pkg::*;
#(
   parameter int W     = 16,
   parameter int CNT_W = 8
) (
   input  logic [W-1:0]     d_i,
   input  logic             carry_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [2:0]       op_i,
   output logic [W-1:0]     res_o,
   output logic             cf_o,
   output logic             of_o
);

   localparam int RW = W + 1;
   localparam logic [CNT_W-1:0] W_C  = CNT_W'(W);
   localparam logic [CNT_W-1:0] RW_C = CNT_W'(RW);

   if (W < 2 || RW >= (1 << CNT_W)) begin : g_bad_width
      $error("shrot_lane: width does not fit the count range");
   end

   // reduced counts
   logic [CNT_W-1:0] rc_cnt;   // through-carry modulo W+1
   logic [CNT_W-1:0] ro_cnt;   // plain rotate modulo W
   logic [CNT_W-1:0] sar_cnt;  // saturated at W

   assign rc_cnt  = cnt_i % RW_C;
   assign ro_cnt  = cnt_i % W_C;
   assign sar_cnt = (cnt_i > W_C) ? W_C : cnt_i;

   // rotate through carry: {carry, operand} as one ring
   logic [RW-1:0] ring;
   logic [RW-1:0] rcl_v;
   logic [RW-1:0] rcr_v;

   assign ring  = {carry_i, d_i};
   assign rcl_v = (ring << rc_cnt) | (ring >> (RW - int'(rc_cnt)));
   assign rcr_v = (ring >> rc_cnt) | (ring << (RW - int'(rc_cnt)));

   // plain rotates
   logic [W-1:0] rol_v;
   logic [W-1:0] ror_v;

   assign rol_v = (d_i << ro_cnt) | (d_i >> (W - int'(ro_cnt)));
   assign ror_v = (d_i >> ro_cnt) | (d_i << (W - int'(ro_cnt)));

   // shifts, with one extra bit that catches the last bit out
   logic [RW-1:0]        shl_v;
   logic [RW-1:0]        shr_v;
   logic signed [RW-1:0] sar_v;

   assign shl_v = {1'b0, d_i} << cnt_i;
   assign shr_v = {d_i, 1'b0} >> cnt_i;
   assign sar_v = $signed({d_i, 1'b0}) >>> sar_cnt;

   always_comb begin
      res_o = d_i;
      cf_o  = carry_i;
      of_o  = 1'b0;
      unique case (shrot_op_e'(op_i))
         OP_ROL: begin
            res_o = rol_v;
            cf_o  = rol_v[0];
            of_o  = rol_v[W-1] ^ rol_v[0];
         end
         OP_ROR: begin
            res_o = ror_v;
            cf_o  = ror_v[W-1];
            of_o  = ror_v[W-1] ^ ror_v[W-2];
         end
         OP_RCL: begin
            res_o = rcl_v[W-1:0];
            cf_o  = rcl_v[W];
            of_o  = rcl_v[W-1] ^ rcl_v[W];
         end
         OP_RCR: begin
            res_o = rcr_v[W-1:0];
            cf_o  = rcr_v[W];
            of_o  = d_i[W-1] ^ carry_i;
         end
         OP_SHL, OP_SHL2: begin
            res_o = shl_v[W-1:0];
            cf_o  = shl_v[W];
            of_o  = shl_v[W-1] ^ shl_v[W];
         end
         OP_SHR: begin
            res_o = shr_v[RW-1:1];
            cf_o  = shr_v[0];
            of_o  = d_i[W-1];
         end
         OP_SAR: begin
            res_o = sar_v[RW-1:1];
            cf_o  = sar_v[0];
            of_o  = 1'b0;
         end
         default: begin
            res_o = d_i;
         end
      endcase
   end

endmodule

// File: rtl/shrot_status.sv
module shrot_status
   import shrot_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic [WORD_W-1:0] res_i,
   input  logic              wide_i,
   input  logic [2:0]        op_i,
   input  logic              zero_cnt_i,
   input  logic              carry_i,
   input  logic              lane_cf_i,
   input  logic              lane_of_i,
   output logic              cf_o,
   output logic              of_o,
   output logic              sf_o,
   output logic              zf_o,
   output logic              pf_o,
   output logic [NFLAGS-1:0] we_o
);

   logic msb;
   logic zero_res;
   logic even_par;

   assign msb      = wide_i ? res_i[WORD_W-1] : res_i[BYTE_W-1];
   assign zero_res = (res_i == '0);
   assign even_par = ~^res_i[7:0];

   always_comb begin
      we_o = '0;
      cf_o = carry_i;
      of_o = 1'b0;
      sf_o = 1'b0;
      zf_o = 1'b0;
      pf_o = 1'b0;
      if (!zero_cnt_i) begin
         cf_o = lane_cf_i;
         of_o = lane_of_i;
         if (op_is_shift(op_i)) begin
            we_o = WE_SHIFT;
            sf_o = msb;
            zf_o = zero_res;
            pf_o = even_par;
         end else begin
            we_o = WE_ROTATE;
         end
      end
   end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
   import shrot_pkg::*;
#(
   parameter int WORD_W        = 16,
   parameter int BYTE_W        = 8,
   parameter int CNT_W         = 8,
   parameter int LATE_CNT_BITS = 5
) (
   input  logic [WORD_W-1:0] opnd_i,
   input  logic              carry_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic [2:0]        op_i,
   input  logic              wide_i,
   input  logic              late_model_i,
   output logic [WORD_W-1:0] result_o,
   output logic              cf_o,
   output logic              of_o,
   output logic              sf_o,
   output logic              zf_o,
   output logic              pf_o,
   output logic [4:0]        flag_we_o
);

   localparam int NSIZE = 2;

   if (BYTE_W < 8 || WORD_W <= BYTE_W || (WORD_W + 1) >= (1 << CNT_W)) begin : g_bad_params
      $error("shrot_unit: inconsistent width parameters");
   end

   logic [CNT_W-1:0] cnt_eff;
   logic             cnt_zero;

   shrot_count #(
      .CNT_W         (CNT_W),
      .LATE_CNT_BITS (LATE_CNT_BITS)
   ) u_count (
      .count_i (count_i),
      .late_i  (late_model_i),
      .eff_o   (cnt_eff),
      .zero_o  (cnt_zero)
   );

   logic [WORD_W-1:0] lane_res [NSIZE];
   logic [NSIZE-1:0]  lane_cf;
   logic [NSIZE-1:0]  lane_of;

   for (genvar g = 0; g < NSIZE; g++) begin : g_lane
      localparam int LW = (g == 0) ? BYTE_W : WORD_W;
      logic [LW-1:0] res_w;

      shrot_lane #(
         .W     (LW),
         .CNT_W (CNT_W)
      ) u_lane (
         .d_i     (opnd_i[LW-1:0]),
         .carry_i (carry_i),
         .cnt_i   (cnt_eff),
         .op_i    (op_i),
         .res_o   (res_w),
         .cf_o    (lane_cf[g]),
         .of_o    (lane_of[g])
      );

      if (LW < WORD_W) begin : g_ext
         assign lane_res[g] = {{(WORD_W-LW){1'b0}}, res_w};
      end else begin : g_full
         assign lane_res[g] = res_w;
      end
   end

   assign result_o = lane_res[wide_i];

   shrot_status #(
      .WORD_W (WORD_W),
      .BYTE_W (BYTE_W)
   ) u_status (
      .res_i      (result_o),
      .wide_i     (wide_i),
      .op_i       (op_i),
      .zero_cnt_i (cnt_zero),
      .carry_i    (carry_i),
      .lane_cf_i  (lane_cf[wide_i]),
      .lane_of_i  (lane_of[wide_i]),
      .cf_o       (cf_o),
      .of_o       (of_o),
      .sf_o       (sf_o),
      .zf_o       (zf_o),
      .pf_o       (pf_o),
      .we_o       (flag_we_o)
   );

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
   parameter int WORD_W        = 16,
   parameter int BYTE_W        = 8,
   parameter int LATE_CNT_BITS = 5
) (
   input logic [WORD_W-1:0]        opnd_i,
   input logic [LATE_CNT_BITS-1:0] cnt_low,
   input logic [2:0]               op_i,
   input logic                     wide_i,
   input logic                     late_model_i,
   input logic [WORD_W-1:0]        result_o,
   input logic                     cf_o,
   input logic                     of_o,
   input logic                     zf_o,
   input logic [4:0]               flag_we_o,
   input logic                     cnt_zero
);

   logic [WORD_W-1:0] opnd_act;
   assign opnd_act = wide_i ? opnd_i : {{(WORD_W-BYTE_W){1'b0}}, opnd_i[BYTE_W-1:0]};

   always_comb begin
      if (!$isunknown({opnd_i, cnt_low, op_i, wide_i, late_model_i, cnt_zero})) begin
         AST_LATE_MASK_ZERO: assert (!(late_model_i && cnt_low == '0) || cnt_zero); // R1
         AST_ZERO_COUNT_IDLE: assert (!cnt_zero || (flag_we_o == 5'b0 && result_o == opnd_act)); // R2
         AST_ROTATE_WE_ONLY: assert (cnt_zero || op_i[2] || flag_we_o == 5'b00011); // R4
         AST_ROL_CF_LSB: assert (cnt_zero || op_i != 3'd0 || cf_o == result_o[0]); // R5
         AST_SAR_OF_CLEAR: assert (cnt_zero || op_i != 3'd7 || !of_o); // R8
         AST_SHIFT_ZF: assert (cnt_zero || !op_i[2] || zf_o == (result_o == '0)); // R10
         AST_BYTE_UPPER_ZERO: assert (wide_i || result_o[WORD_W-1:BYTE_W] == '0); // R11
      end
   end

endmodule

bind shrot_unit shrot_unit_chk #(
   .WORD_W        (WORD_W),
   .BYTE_W        (BYTE_W),
   .LATE_CNT_BITS (LATE_CNT_BITS)
) u_chk (
   .opnd_i       (opnd_i),
   .cnt_low      (count_i[LATE_CNT_BITS-1:0]),
   .op_i         (op_i),
   .wide_i       (wide_i),
   .late_model_i (late_model_i),
   .result_o     (result_o),
   .cf_o         (cf_o),
   .of_o         (of_o),
   .zf_o         (zf_o),
   .flag_we_o    (flag_we_o),
   .cnt_zero     (cnt_zero)
);

// File: tb/tb_shrot_unit.sv
`timescale 1ns/1ps
module tb_shrot_unit;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [15:0] opnd_i;
   logic        carry_i;
   logic [7:0]  count_i;
   logic [2:0]  op_i;
   logic        wide_i;
   logic        late_model_i;
   logic [15:0] result_o;
   logic        cf_o, of_o, sf_o, zf_o, pf_o;
   logic [4:0]  flag_we_o;

   shrot_unit dut (
      .opnd_i       (opnd_i),
      .carry_i      (carry_i),
      .count_i      (count_i),
      .op_i         (op_i),
      .wide_i       (wide_i),
      .late_model_i (late_model_i),
      .result_o     (result_o),
      .cf_o         (cf_o),
      .of_o         (of_o),
      .sf_o         (sf_o),
      .zf_o         (zf_o),
      .pf_o         (pf_o),
      .flag_we_o    (flag_we_o)
   );

   typedef struct {
      logic [15:0] res;
      logic        cf, of, sf, zf, pf;
      logic [4:0]  we;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_run  = 0;
   int   n_fail = 0;
   int   cycles = 0;
   bit   done   = 0;

   function automatic exp_t model(input logic [2:0] op, input logic [15:0] d, input logic cin,
                                  input logic [7:0] cnt, input logic wide, input logic late,
                                  input string tag);
      exp_t e;
      int w, mc, t;
      logic [15:0] dd, mask;
      logic c, b, s;
      w    = wide ? 16 : 8;
      mask = wide ? 16'hFFFF : 16'h00FF;
      dd   = d & mask;
      mc   = late ? int'(cnt & 8'h1F) : int'(cnt);
      e.tag = tag;
      e.res = dd; e.cf = cin; e.of = 0; e.sf = 0; e.zf = 0; e.pf = 0; e.we = 5'b0;
      if (mc == 0) return e;
      c = cin;
      case (op)
         3'd0: begin
            t = mc % w;
            for (int k = 0; k < t; k++) begin b = dd[w-1]; dd = ((dd << 1) | 16'(b)) & mask; end
            e.cf = dd[0]; e.of = dd[w-1] ^ dd[0]; e.we = 5'b00011;
         end
         3'd1: begin
            t = mc % w;
            for (int k = 0; k < t; k++) begin b = dd[0]; dd = (dd >> 1) | (16'(b) << (w-1)); end
            e.cf = dd[w-1]; e.of = dd[w-1] ^ dd[w-2]; e.we = 5'b00011;
         end
         3'd2: begin
            t = mc % (w + 1);
            for (int k = 0; k < t; k++) begin b = dd[w-1]; dd = ((dd << 1) | 16'(c)) & mask; c = b; end
            e.cf = c; e.of = dd[w-1] ^ c; e.we = 5'b00011;
         end
         3'd3: begin
            t = mc % (w + 1);
            e.of = dd[w-1] ^ cin;
            for (int k = 0; k < t; k++) begin b = dd[0]; dd = (dd >> 1) | (16'(c) << (w-1)); c = b; end
            e.cf = c; e.we = 5'b00011;
         end
         3'd4, 3'd6: begin
            c = 0;
            for (int k = 0; k < mc; k++) begin c = dd[w-1]; dd = (dd << 1) & mask; end
            e.cf = c; e.of = dd[w-1] ^ c;
         end
         3'd5: begin
            e.of = dd[w-1];
            for (int k = 0; k < mc; k++) begin c = dd[0]; dd = dd >> 1; end
            e.cf = c;
         end
         default: begin
            s = dd[w-1];
            for (int k = 0; k < mc; k++) begin c = dd[0]; dd = (dd >> 1) | (16'(s) << (w-1)); end
            e.cf = c; e.of = 0;
         end
      endcase
      e.res = dd;
      if (op[2]) begin
         e.we = 5'b11111; e.sf = dd[w-1]; e.zf = (dd == 0); e.pf = ~^dd[7:0];
      end
      return e;
   endfunction

   task automatic drive(input logic [2:0] op, input logic [15:0] d, input logic cin,
                        input logic [7:0] cnt, input logic wide, input logic late, input string tag);
      @(negedge clk);
      op_i = op; opnd_i = d; carry_i = cin; count_i = cnt; wide_i = wide; late_model_i = late;
      exp_q.push_back(model(op, d, cin, cnt, wide, late, tag));
   endtask

   // monitor: compare at the rising edge after each negedge drive
   always @(posedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_run++;
         if ({result_o, cf_o, of_o, sf_o, zf_o, pf_o, flag_we_o} !==
             {e.res, e.cf, e.of, e.sf, e.zf, e.pf, e.we}) begin
            n_fail++;
            $display("FAIL %s: actual res=%h cf=%b of=%b sf=%b zf=%b pf=%b we=%b expected res=%h cf=%b of=%b sf=%b zf=%b pf=%b we=%b",
                     e.tag, result_o, cf_o, of_o, sf_o, zf_o, pf_o, flag_we_o,
                     e.res, e.cf, e.of, e.sf, e.zf, e.pf, e.we);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles >= 50000 && !done) begin
         n_fail++;
         $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      opnd_i = 16'h1234; carry_i = 1'b1; count_i = 8'd0; op_i = 3'd4; wide_i = 1'b1; late_model_i = 1'b0;
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      // R2: idle pass-through after reset, zero counts
      drive(3'd4, 16'h1234, 1'b1, 8'd0,   1'b1, 1'b0, "R2 zero count shl");
      drive(3'd0, 16'hBEEF, 1'b0, 8'h20,  1'b1, 1'b1, "R2 R1 late mask to zero");
      drive(3'd2, 16'hABCD, 1'b1, 8'd0,   1'b0, 1'b0, "R2 byte zero count");
      // R1: model masking
      drive(3'd0, 16'hBEEF, 1'b0, 8'h20,  1'b1, 1'b0, "R1 early full count rol");
      drive(3'd5, 16'h8421, 1'b0, 8'h21,  1'b1, 1'b1, "R1 late shr count 1");
      drive(3'd5, 16'h8421, 1'b0, 8'h21,  1'b1, 1'b0, "R1 early shr count 33");
      // R3: rotate through carry
      drive(3'd2, 16'h8001, 1'b0, 8'd1,   1'b1, 1'b0, "R3 rcl word 1");
      drive(3'd2, 16'h1234, 1'b1, 8'd17,  1'b1, 1'b0, "R3 rcl word mod 17");
      drive(3'd2, 16'h00F0, 1'b1, 8'd16,  1'b1, 1'b0, "R3 rcl word 16");
      drive(3'd3, 16'h0081, 1'b1, 8'd9,   1'b0, 1'b0, "R3 rcr byte mod 9");
      drive(3'd3, 16'h0081, 1'b0, 8'd8,   1'b0, 1'b0, "R3 rcr byte 8");
      drive(3'd3, 16'h8000, 1'b0, 8'd1,   1'b1, 1'b0, "R3 rcr word of");
      drive(3'd2, 16'h0055, 1'b1, 8'd200, 1'b0, 1'b0, "R3 R4 rcl byte 200");
      // R5, R6: plain rotates
      drive(3'd0, 16'h0081, 1'b0, 8'd1,   1'b0, 1'b0, "R5 R6 rol byte 1");
      drive(3'd1, 16'h0001, 1'b0, 8'd1,   1'b0, 1'b0, "R5 R6 ror byte 1");
      drive(3'd1, 16'h00C3, 1'b1, 8'd8,   1'b0, 1'b0, "R5 ror byte mod 8");
      drive(3'd1, 16'h4001, 1'b0, 8'd3,   1'b1, 1'b1, "R6 ror word 3");
      // R7: shift left
      drive(3'd4, 16'h0001, 1'b0, 8'd16,  1'b1, 1'b0, "R7 shl count eq width");
      drive(3'd4, 16'hFFFF, 1'b1, 8'd17,  1'b1, 1'b0, "R7 shl count above width");
      drive(3'd6, 16'h6001, 1'b0, 8'd3,   1'b1, 1'b0, "R7 shl alias op 6");
      drive(3'd4, 16'h0041, 1'b0, 8'd1,   1'b0, 1'b0, "R7 shl byte of");
      // R8: arithmetic shift right
      drive(3'd7, 16'h8000, 1'b0, 8'd20,  1'b1, 1'b0, "R8 sar word above width");
      drive(3'd7, 16'h0080, 1'b0, 8'd8,   1'b0, 1'b0, "R8 sar byte eq width");
      drive(3'd7, 16'h0040, 1'b1, 8'd3,   1'b0, 1'b0, "R8 sar byte positive");
      // R9: logical shift right
      drive(3'd5, 16'h8000, 1'b0, 8'd16,  1'b1, 1'b0, "R9 shr count eq width");
      drive(3'd5, 16'hFFFF, 1'b1, 8'd17,  1'b1, 1'b0, "R9 shr count above width");
      drive(3'd5, 16'h8001, 1'b0, 8'd1,   1'b1, 1'b0, "R9 shr word 1");
      // R10, R11: flags and byte mode
      drive(3'd4, 16'h0003, 1'b0, 8'd1,   1'b0, 1'b0, "R10 parity even");
      drive(3'd5, 16'h0002, 1'b0, 8'd1,   1'b0, 1'b0, "R10 parity odd");
      drive(3'd5, 16'hABCD, 1'b0, 8'd2,   1'b0, 1'b0, "R11 byte upper ignored");
      drive(3'd0, 16'hFF00, 1'b1, 8'd3,   1'b0, 1'b0, "R11 R4 byte rol zero low");
      for (int i = 0; i < 600; i++) begin
         drive(3'($urandom), 16'($urandom), 1'($urandom), 8'($urandom), 1'($urandom),
               1'($urandom), "R10 random mix");
      end
      @(negedge clk);
      while (exp_q.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule